// File: doc/BRIEF.md
# Cache Snoop Coherency Controller

This block watches every SDRAM access made by a bus master other than the processor and keeps the processor's data cache coherent with memory. It holds a small direct-mapped shadow of the cache's tag, valid and dirty state. It looks up each external access's line address in that shadow in the same cycle the access is presented. The processor side reports its own line fills and writes through a separate update port, so the shadow tracks which lines are present and which hold modified data.

A static policy input selects the action taken on a hit. In write-back policy, reads and writes from other masters are both snooped. A hit on a modified line stalls the requester and issues a line write-back request. The access is released only after the write-back is acknowledged. After that, a read leaves the line clean and a write removes it. A write that hits a clean line removes it with no stall. In write-through policy, only writes are snooped, and a hit removes the line in the same cycle with no stall and no write-back. Every removal is reported on an invalidate strobe with the line index, so the cache itself can drop the line. All addresses on the ports are line addresses: the byte address with the 4 offset bits of a 16-byte line removed.

Top module: `snoop_coherency_ctrl`

## Requirements
- R1: After reset every line is invalid, and stall_o, wb_req_o and inv_o are low; no external access stalls or invalidates until a processor update has filled a line.
- R2: A processor update (cpu_stb_i) installs the tag of cpu_line_i at its index and marks the line valid. In write-back policy (mode_wt_i=0), cpu_we_i=1 marks the line modified. A read that matches the tag already held keeps an existing modified mark. In write-through policy (mode_wt_i=1), a line is never marked modified.
- R3: In write-back policy, an external read or write that hits a modified line raises stall_o in the cycle the strobe is presented. From the next cycle on, wb_req_o is high with wb_line_o equal to the hit line address.
- R4: stall_o and wb_req_o stay high, and wb_line_o stays unchanged, until wb_ack_i is sampled high. Both fall in the cycle after the acknowledge.
- R5: When the write-back is acknowledged, a read access leaves the line valid and clean. A write access removes the line, and inv_o pulses with inv_idx_o set to the line index in the acknowledge cycle.
- R6: In write-back policy, an external write that hits a clean line raises inv_o with the line index in the same cycle, does not stall, and leaves the line invalid.
- R7: An external read that hits a clean line, and any access that misses, causes no stall, no write-back request and no invalidate.
- R8: In write-through policy, external reads are not snooped: even on a hit they raise neither stall_o nor inv_o, and the line is left unchanged.
- R9: In write-through policy, an external write that hits raises inv_o in the same cycle, never raises stall_o or wb_req_o, and leaves the line invalid.
- R10: The line index is the low 4 bits of the line address and the tag is the remaining upper bits. An access whose tag differs from the one held at its index is a miss.
- R11: A processor update to the index that is waiting for a write-back is dropped, and the line keeps its tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wt_i | input | 1 | Write policy: 1 = write-through, 0 = write-back; static while traffic runs |
| ext_stb_i | input | 1 | External master access strobe, held until accepted |
| ext_we_i | input | 1 | External access is a write |
| ext_line_i | input | 28 | External access line address |
| cpu_stb_i | input | 1 | Processor cache fill or write update |
| cpu_we_i | input | 1 | Processor update is a write |
| cpu_line_i | input | 28 | Processor update line address |
| stall_o | output | 1 | Holds the external access off |
| wb_req_o | output | 1 | Line write-back request |
| wb_line_o | output | 28 | Line address to write back |
| wb_ack_i | input | 1 | Write-back done |
| inv_o | output | 1 | Line invalidate strobe towards the cache |
| inv_idx_o | output | 4 | Index of the line being invalidated |

## Verification
The assertions assume that the policy input does not change while an access is pending. They also assume that an external master keeps its strobe, direction and address steady while stall_o is high, and that wb_ack_i is raised only while wb_req_o is high. The directed tests change the policy only between scenarios, with the strobe low and no write-back open. Each stalled access is held until the cycle after its acknowledge, and the acknowledge is driven for a single cycle inside an open request.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FLUSH = 1'b1
  } snp_state_e;
endpackage

// File: rtl/snoop_tag_array.sv
module snoop_tag_array #(
  parameter int LINE_W = 28,
  parameter int LINES  = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = LINE_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] lk_line_i,
  output logic              lk_hit_o,
  output logic              lk_dirty_o,
  input  logic              snp_inv_i,
  input  logic              snp_clean_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  logic              cpu_upd_i,
  input  logic              cpu_dirty_i,
  input  logic [LINE_W-1:0] cpu_line_i
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] valid_q, dirty_q;

  logic [IDX_W-1:0] lk_idx, cpu_idx;
  logic [TAG_W-1:0] lk_tag, cpu_tag;

  assign lk_idx  = lk_line_i[IDX_W-1:0];
  assign lk_tag  = lk_line_i[LINE_W-1:IDX_W];
  assign cpu_idx = cpu_line_i[IDX_W-1:0];
  assign cpu_tag = cpu_line_i[LINE_W-1:IDX_W];

  assign lk_hit_o   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_dirty_o = dirty_q[lk_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [TAG_W-1:0] tag_r;
    logic             v_r, d_r;
    logic             snp_sel, cpu_sel, same_tag;

    assign snp_sel  = (snp_inv_i || snp_clean_i) && (snp_idx_i == IDX_W'(g));
    assign cpu_sel  = cpu_upd_i && (cpu_idx == IDX_W'(g));
    assign same_tag = v_r && (tag_r == cpu_tag);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_r <= '0;
        v_r   <= 1'b0;
        d_r   <= 1'b0;
      end else if (snp_sel) begin
        // snoop update wins over a processor update to the same line
        if (snp_inv_i) v_r <= 1'b0;
        d_r <= 1'b0;
      end else if (cpu_sel) begin
        tag_r <= cpu_tag;
        v_r   <= 1'b1;
        d_r   <= cpu_dirty_i || (same_tag && d_r);
      end
    end

    assign tag_q[g]   = tag_r;
    assign valid_q[g] = v_r;
    assign dirty_q[g] = d_r;
  end
endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int LINE_W = 28,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wt_i,
  input  logic              ext_stb_i,
  input  logic              ext_we_i,
  input  logic [LINE_W-1:0] ext_line_i,
  input  logic              hit_i,
  input  logic              dirty_i,
  input  logic              wb_ack_i,
  output logic              stall_o,
  output logic              wb_req_o,
  output logic [LINE_W-1:0] wb_line_o,
  output logic              inv_o,
  output logic              clean_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o
);
  snp_state_e        state_q, state_d;
  logic [LINE_W-1:0] line_q;
  logic              op_we_q;
  logic              snoop_en, flush_start;

  // write-through snoops writes only
  assign snoop_en    = ext_stb_i && (!mode_wt_i || ext_we_i);
  assign flush_start = (state_q == ST_IDLE) && snoop_en && hit_i && !mode_wt_i && dirty_i;

  always_comb begin
    state_d  = state_q;
    stall_o  = 1'b0;
    wb_req_o = 1'b0;
    inv_o    = 1'b0;
    clean_o  = 1'b0;
    idx_o    = ext_line_i[IDX_W-1:0];
    unique case (state_q)
      ST_IDLE: begin
        if (flush_start) begin
          stall_o = 1'b1;
          state_d = ST_FLUSH;
        end else if (snoop_en && hit_i && ext_we_i) begin
          inv_o = 1'b1;
        end
      end
      ST_FLUSH: begin
        stall_o  = 1'b1;
        wb_req_o = 1'b1;
        idx_o    = line_q[IDX_W-1:0];
        if (wb_ack_i) begin
          inv_o   = op_we_q;
          clean_o = !op_we_q;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      line_q  <= '0;
      op_we_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (flush_start) begin
        line_q  <= ext_line_i;
        op_we_q <= ext_we_i;
      end
    end
  end

  assign wb_line_o = line_q;
  assign busy_o    = (state_q == ST_FLUSH);
endmodule

// File: rtl/snoop_coherency_ctrl.sv
module snoop_coherency_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 16,
  parameter int LINE_BYTES = 16,
  localparam int OFS_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFS_W,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wt_i,
  input  logic              ext_stb_i,
  input  logic              ext_we_i,
  input  logic [LINE_W-1:0] ext_line_i,
  input  logic              cpu_stb_i,
  input  logic              cpu_we_i,
  input  logic [LINE_W-1:0] cpu_line_i,
  output logic              stall_o,
  output logic              wb_req_o,
  output logic [LINE_W-1:0] wb_line_o,
  input  logic              wb_ack_i,
  output logic              inv_o,
  output logic [IDX_W-1:0]  inv_idx_o
);
  logic             hit, dirty;
  logic             snp_inv, snp_clean, busy;
  logic [IDX_W-1:0] snp_idx;
  logic             cpu_upd, cpu_dirty;

  // drop processor updates to a line awaiting write-back
  assign cpu_upd   = cpu_stb_i && !(busy && (cpu_line_i[IDX_W-1:0] == snp_idx));
  assign cpu_dirty = cpu_we_i && !mode_wt_i;

  snoop_tag_array #(
    .LINE_W (LINE_W),
    .LINES  (LINES)
  ) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_line_i   (ext_line_i),
    .lk_hit_o    (hit),
    .lk_dirty_o  (dirty),
    .snp_inv_i   (snp_inv),
    .snp_clean_i (snp_clean),
    .snp_idx_i   (snp_idx),
    .cpu_upd_i   (cpu_upd),
    .cpu_dirty_i (cpu_dirty),
    .cpu_line_i  (cpu_line_i)
  );

  snoop_ctrl #(
    .LINE_W (LINE_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wt_i  (mode_wt_i),
    .ext_stb_i  (ext_stb_i),
    .ext_we_i   (ext_we_i),
    .ext_line_i (ext_line_i),
    .hit_i      (hit),
    .dirty_i    (dirty),
    .wb_ack_i   (wb_ack_i),
    .stall_o    (stall_o),
    .wb_req_o   (wb_req_o),
    .wb_line_o  (wb_line_o),
    .inv_o      (snp_inv),
    .clean_o    (snp_clean),
    .idx_o      (snp_idx),
    .busy_o     (busy)
  );

  assign inv_o     = snp_inv;
  assign inv_idx_o = snp_idx;
endmodule

// File: rtl/snoop_coherency_checker.sv
module snoop_coherency_checker #(
  parameter int LINE_W = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_wt_i,
  input logic              ext_stb_i,
  input logic              ext_we_i,
  input logic              stall_o,
  input logic              wb_req_o,
  input logic [LINE_W-1:0] wb_line_o,
  input logic              wb_ack_i,
  input logic              inv_o
);
  a_r4_stall_while_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> stall_o);

  a_r4_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && !wb_ack_i) |=> (wb_req_o && $stable(wb_line_o)));

  a_r4_release_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_req_o && wb_ack_i) |=> (!wb_req_o && !stall_o));

  a_r3_req_after_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wb_req_o) |-> ($past(stall_o) && $past(ext_stb_i)));

  a_r9_wt_never_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wt_i |-> (!stall_o && !wb_req_o));

  a_r8_wt_read_no_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wt_i && !ext_we_i) |-> !inv_o);

  a_r6_inv_without_wb_no_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_o && !wb_req_o) |-> !stall_o);
endmodule

bind snoop_coherency_ctrl snoop_coherency_checker #(.LINE_W(LINE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_wt_i (mode_wt_i),
  .ext_stb_i (ext_stb_i),
  .ext_we_i  (ext_we_i),
  .stall_o   (stall_o),
  .wb_req_o  (wb_req_o),
  .wb_line_o (wb_line_o),
  .wb_ack_i  (wb_ack_i),
  .inv_o     (inv_o)
);

// File: tb/tb_snoop_coherency_ctrl.sv
module tb_snoop_coherency_ctrl;
  localparam int LINE_W = 28;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mode_wt_i = 1'b0;
  logic              ext_stb_i = 1'b0, ext_we_i = 1'b0;
  logic [LINE_W-1:0] ext_line_i = '0;
  logic              cpu_stb_i = 1'b0, cpu_we_i = 1'b0;
  logic [LINE_W-1:0] cpu_line_i = '0;
  logic              stall_o, wb_req_o, wb_ack_i = 1'b0, inv_o;
  logic [LINE_W-1:0] wb_line_o;
  logic [IDX_W-1:0]  inv_idx_o;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  snoop_coherency_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_wt_i(mode_wt_i),
    .ext_stb_i(ext_stb_i), .ext_we_i(ext_we_i), .ext_line_i(ext_line_i),
    .cpu_stb_i(cpu_stb_i), .cpu_we_i(cpu_we_i), .cpu_line_i(cpu_line_i),
    .stall_o(stall_o), .wb_req_o(wb_req_o), .wb_line_o(wb_line_o),
    .wb_ack_i(wb_ack_i), .inv_o(inv_o), .inv_idx_o(inv_idx_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #6;
  endtask

  task automatic cpu_op(input logic [LINE_W-1:0] line, input logic we);
    cpu_stb_i = 1'b1; cpu_we_i = we; cpu_line_i = line;
    tick();
    cpu_stb_i = 1'b0; cpu_we_i = 1'b0;
  endtask

  // single-cycle external access: check outputs, then complete it
  task automatic ext_once(input string req, input logic [LINE_W-1:0] line, input logic we,
                          input logic exp_stall, input logic exp_inv);
    ext_stb_i = 1'b1; ext_we_i = we; ext_line_i = line;
    settle();
    chk({req, " stall"}, 32'(stall_o), 32'(exp_stall));
    chk({req, " inv"}, 32'(inv_o), 32'(exp_inv));
    if (exp_inv) chk({req, " inv_idx"}, 32'(inv_idx_o), 32'(line[IDX_W-1:0]));
    tick();
    ext_stb_i = 1'b0; ext_we_i = 1'b0;
  endtask

  // dirty-hit flow: stall, request, hold, ack, release
  task automatic ext_flush(input string req, input logic [LINE_W-1:0] line, input logic we,
                           input int hold);
    ext_stb_i = 1'b1; ext_we_i = we; ext_line_i = line;
    settle();
    chk({req, " R3 stall on hit"}, 32'(stall_o), 1);
    chk({req, " R3 no req yet"}, 32'(wb_req_o), 0);
    tick(); settle();
    chk({req, " R3 req"}, 32'(wb_req_o), 1);
    chk({req, " R3 wb_line"}, 32'(wb_line_o), 32'(line));
    for (int i = 0; i < hold; i++) begin
      tick(); settle();
      chk({req, " R4 stall held"}, 32'(stall_o), 1);
      chk({req, " R4 line held"}, 32'(wb_line_o), 32'(line));
    end
    tick();
    wb_ack_i = 1'b1;
    settle();
    chk({req, " R4 stall in ack cycle"}, 32'(stall_o), 1);
    chk({req, " R5 inv on ack"}, 32'(inv_o), 32'(we));
    if (we) chk({req, " R5 inv_idx"}, 32'(inv_idx_o), 32'(line[IDX_W-1:0]));
    tick();
    wb_ack_i = 1'b0;
    settle();
    chk({req, " R4 stall released"}, 32'(stall_o), 0);
    chk({req, " R4 req released"}, 32'(wb_req_o), 0);
    tick();
    ext_stb_i = 1'b0; ext_we_i = 1'b0;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 stall", 32'(stall_o), 0);
    chk("R1 wb_req", 32'(wb_req_o), 0);
    chk("R1 inv", 32'(inv_o), 0);
    ext_once("R1 read empty", 28'h0000123, 1'b0, 1'b0, 1'b0);
    ext_once("R1 write empty", 28'h0000123, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_wb_read_dirty();
    cpu_op(28'h0000123, 1'b1);
    cpu_op(28'h0000123, 1'b0);  // R2: same-tag read keeps dirty
    ext_flush("R2 R3 read", 28'h0000123, 1'b0, 2);
    ext_once("R5 read clean after wb", 28'h0000123, 1'b0, 1'b0, 1'b0);
    ext_once("R6 write clean hit", 28'h0000123, 1'b1, 1'b0, 1'b1);
    ext_once("R6 line gone", 28'h0000123, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_wb_write_dirty();
    cpu_op(28'h0000567, 1'b1);
    ext_flush("R5 write", 28'h0000567, 1'b1, 0);
    ext_once("R5 line removed", 28'h0000567, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_miss();
    cpu_op(28'h00001A5, 1'b0);
    ext_once("R10 R7 read other tag", 28'h00002B5, 1'b0, 1'b0, 1'b0);
    ext_once("R10 write other tag", 28'h00002B5, 1'b1, 1'b0, 1'b0);
    ext_once("R7 read clean hit", 28'h00001A5, 1'b0, 1'b0, 1'b0);
    ext_once("R10 write own tag", 28'h00001A5, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_write_through();
    mode_wt_i = 1'b1;
    tick();
    cpu_op(28'h0000999, 1'b1);
    ext_once("R8 read hit ignored", 28'h0000999, 1'b0, 1'b0, 1'b0);
    ext_once("R9 write hit", 28'h0000999, 1'b1, 1'b0, 1'b1);
    chk("R9 no wb_req", 32'(wb_req_o), 0);
    ext_once("R9 line gone", 28'h0000999, 1'b1, 1'b0, 1'b0);
    cpu_op(28'h0000999, 1'b1);
    mode_wt_i = 1'b0;
    tick();
    ext_once("R2 not dirty in wt", 28'h0000999, 1'b0, 1'b0, 1'b0);
    ext_once("R2 still valid", 28'h0000999, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_block();
    cpu_op(28'h0000333, 1'b1);
    ext_stb_i = 1'b1; ext_we_i = 1'b0; ext_line_i = 28'h0000333;
    settle();
    chk("R11 stall", 32'(stall_o), 1);
    tick();
    cpu_stb_i = 1'b1; cpu_we_i = 1'b0; cpu_line_i = 28'h0000443;
    settle();
    chk("R11 req", 32'(wb_req_o), 1);
    tick();
    cpu_stb_i = 1'b0;
    wb_ack_i = 1'b1;
    tick();
    wb_ack_i = 1'b0;
    settle();
    chk("R11 released", 32'(stall_o), 0);
    tick();
    ext_stb_i = 1'b0;
    ext_once("R11 tag kept read", 28'h0000333, 1'b0, 1'b0, 1'b0);
    ext_once("R11 tag kept write", 28'h0000333, 1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    tick();
    t_reset();
    t_wb_read_dirty();
    t_wb_write_dirty();
    t_miss();
    t_write_through();
    t_block();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule